// File: doc/BRIEF.md
# Single-Wire Half-Duplex Link Target

This block is the responding end of a link in which two devices share one data line. The line idles high. The initiator opens a transaction by pulling the line low. It then sends a 4-bit transaction index. The target checks that index against its parity bit. If the check passes, the target raises a short presence acknowledge and speaks first: it sends the payload bytes stored for that index. It then turns the line round and receives the bytes the initiator sends back. For each index it keeps a status code that a clear strobe can reset.

Every transfer on the line is a chunk, and every chunk begins with a sync. A sync is one bit period low followed by half a bit period high, and its rising edge marks the timing reference. After the sync come the data bits, most significant bit first, each one bit period long. The chunk ends with a parity bit, and the sender then drives the line low. The receiver samples each bit in the middle of its period.

The bytes to send are fetched through a read port addressed by index and byte offset. Received bytes leave through a write port with the same addressing. The payload lengths for each index are supplied as packed inputs.

Top module: `swire_target`

## Requirements
- R1: After reset the line is released (`line_oe_o` low), `wr_en_o` is low and every status code is 0.
- R2: A falling edge on the idle line starts a transaction. The index arrives as 4 bits, MSB first, followed by one parity bit equal to the XOR of the 4 bits. If the parity does not match, the target never drives the line and leaves every status code unchanged.
- R3: After a good index the target waits half a bit period after the parity sample. It then drives the line high for ACK_UNIT*ACK_WIDTH clocks and then drives it low.
- R4: The target sends tx_len[idx] bytes, read at offsets 0 upward from `rd_data_i` with `rd_idx_o` set to the index. Each byte is framed as a sync (BIT_CLKS clocks low, BIT_CLKS/2 clocks high), then 8 bits MSB first at BIT_CLKS clocks each, then a parity bit equal to the XOR of the 8 bits.
- R5: After the last transmitted byte, or straight after the acknowledge when tx_len is 0, the target sends a turnaround sync. The high part lasts BIT_CLKS/2 clocks. The target then drives the line low for exactly one clock and releases it, and it never drives while the initiator does.
- R6: The target receives rx_len[idx] bytes in the same framing, sampling each bit mid-period. For each byte it issues a one-cycle `wr_en_o` pulse carrying the index, the offset (0 upward) and the data, including bytes that fail parity.
- R7: After the last received byte, status[idx] becomes 2 if any received byte failed parity in that transaction, and 1 otherwise. The code is 2 bits wide and sits at `status_o[2*idx +: 2]`. Errors from an earlier transaction do not carry over.
- R8: When rx_len[idx] is 0, status[idx] becomes 1 once the turnaround is complete.
- R9: Falling edges that arrive while a transaction is in progress are ignored. A transaction ends, and a new start is accepted, only after the line has been low and then returns high. This includes a transaction dropped for bad index parity.
- R10: A pulse on `clr_i[i]` sets status[i] to 0 and leaves every other index untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sampled level of the shared line |
| line_oe_o | output | 1 | Target drives the line when high |
| line_o | output | 1 | Level driven while `line_oe_o` is high |
| tx_len_i | input | 16*LEN_W | Bytes to send for each index, LEN_W bits per index at idx*LEN_W |
| rx_len_i | input | 16*LEN_W | Bytes to receive for each index, same packing |
| rd_idx_o | output | 4 | Index of the byte being fetched |
| rd_off_o | output | LEN_W | Offset of the byte being fetched |
| rd_data_i | input | 8 | Byte at the read address (combinational) |
| wr_en_o | output | 1 | One-cycle write strobe for a received byte |
| wr_idx_o | output | 4 | Index for the write |
| wr_off_o | output | LEN_W | Offset for the write |
| wr_data_o | output | 8 | Received byte |
| clr_i | input | 16 | Per-index status clear strobes |
| status_o | output | 32 | Per-index 2-bit status codes: 0 none, 1 accepted, 2 data error |

## Verification
Several properties are checked on every cycle:
- the first level the target drives is always the high half of the acknowledge;
- the target releases the line only from a low level;
- write strobes last exactly one cycle and stay inside the configured receive length;
- a clear strobe zeroes its status unless a status update for the same index lands in the same cycle;
- status is never updated while the target drives.

Other behaviour can only be shown by the bench, which plays the initiator over every index with mixed lengths and injected parity faults:
- the exact widths of the acknowledge and the turnaround;
- the byte and parity values on the line;
- the dropping of bad indices;
- recovery afterwards;
- the status codes that result.

// File: rtl/swire_target.sv
module swire_target #(
  parameter int BIT_CLKS  = 16,
  parameter int ACK_UNIT  = 2,
  parameter int ACK_WIDTH = 4,
  parameter int LEN_W     = 3,
  localparam int NIDX     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_i,
  output logic                  line_oe_o,
  output logic                  line_o,
  input  logic [NIDX*LEN_W-1:0] tx_len_i,
  input  logic [NIDX*LEN_W-1:0] rx_len_i,
  output logic [3:0]            rd_idx_o,
  output logic [LEN_W-1:0]      rd_off_o,
  input  logic [7:0]            rd_data_i,
  output logic                  wr_en_o,
  output logic [3:0]            wr_idx_o,
  output logic [LEN_W-1:0]      wr_off_o,
  output logic [7:0]            wr_data_o,
  input  logic [NIDX-1:0]       clr_i,
  output logic [2*NIDX-1:0]     status_o
);
  localparam int HALF     = BIT_CLKS / 2;
  localparam int ACK_CLKS = ACK_UNIT * ACK_WIDTH;
  localparam int CW       = $clog2(BIT_CLKS + ACK_CLKS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WLOW, S_WHIGH, S_RXBIT, S_ACKW, S_ACKH,
    S_SYNL, S_SYNH, S_TBIT, S_DROP, S_TAW
  } st_t;
  typedef enum logic [1:0] {C_IDX, C_RXB, C_END} ctx_t;

  st_t              state;
  ctx_t             ctx;
  logic             l1, l2, l3;
  logic [CW-1:0]    cnt;
  logic [3:0]       nb;
  logic [LEN_W-1:0] off;
  logic [3:0]       idx;
  logic [7:0]       sh;
  logic             par, err, turn;
  logic [8:0]       tsh;
  logic             set_en;
  logic [1:0]       set_code;

  wire              fall   = l3 & ~l2;
  wire [LEN_W-1:0]  cur_tx = tx_len_i[int'(idx)*LEN_W +: LEN_W];
  wire [LEN_W-1:0]  cur_rx = rx_len_i[int'(idx)*LEN_W +: LEN_W];
  wire [LEN_W:0]    off_inc = {1'b0, off} + 1'b1;
  wire [3:0]        ndat   = (ctx == C_IDX) ? 4'd4 : 4'd8;
  wire              bad    = par ^ l2;

  assign line_oe_o = (state == S_ACKH) | (state == S_SYNL) | (state == S_SYNH) |
                     (state == S_TBIT) | (state == S_DROP);
  assign line_o    = (state == S_ACKH) | (state == S_SYNH) | ((state == S_TBIT) & tsh[8]);
  assign rd_idx_o  = idx;
  assign rd_off_o  = off;
  assign wr_idx_o  = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1 <= 1'b1; l2 <= 1'b1; l3 <= 1'b1;
    end else begin
      l1 <= line_i; l2 <= l1; l3 <= l2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ctx <= C_IDX; cnt <= '0; nb <= '0; off <= '0; idx <= '0;
      sh <= '0; par <= 1'b0; err <= 1'b0; turn <= 1'b0; tsh <= '0;
      wr_en_o <= 1'b0; wr_off_o <= '0; wr_data_o <= '0; set_en <= 1'b0; set_code <= '0;
    end else begin
      wr_en_o <= 1'b0;
      set_en  <= 1'b0;
      case (state)
        S_IDLE: if (fall) begin ctx <= C_IDX; state <= S_WLOW; end
        S_WLOW: if (!l2) state <= S_WHIGH;
        S_WHIGH: if (l2) begin
          if (ctx == C_END) state <= S_IDLE;
          else begin
            state <= S_RXBIT; cnt <= CW'(BIT_CLKS - 1); nb <= '0; par <= 1'b0;
          end
        end
        S_RXBIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (nb < ndat) begin
            sh <= {sh[6:0], l2}; par <= par ^ l2; nb <= nb + 1'b1; cnt <= CW'(BIT_CLKS - 1);
          end else if (ctx == C_IDX) begin
            if (bad) begin ctx <= C_END; state <= S_WLOW; end
            else begin idx <= sh[3:0]; cnt <= CW'(HALF - 1); state <= S_ACKW; end
          end else begin
            wr_en_o <= 1'b1; wr_off_o <= off; wr_data_o <= sh;
            err <= err | bad;
            state <= S_WLOW;
            if (off_inc == {1'b0, cur_rx}) begin
              set_en <= 1'b1; set_code <= (err | bad) ? 2'd2 : 2'd1; ctx <= C_END;
            end else off <= off_inc[LEN_W-1:0];
          end
        end
        S_ACKW: if (cnt != '0) cnt <= cnt - 1'b1;
                else begin cnt <= CW'(ACK_CLKS - 1); state <= S_ACKH; end
        S_ACKH: if (cnt != '0) cnt <= cnt - 1'b1;
                else begin
                  cnt <= CW'(BIT_CLKS - 1); off <= '0; turn <= (cur_tx == '0); state <= S_SYNL;
                end
        S_SYNL: if (cnt != '0) cnt <= cnt - 1'b1;
                else begin
                  cnt <= CW'(HALF - 1); tsh <= {rd_data_i, ^rd_data_i}; state <= S_SYNH;
                end
        S_SYNH: if (cnt != '0) cnt <= cnt - 1'b1;
                else if (turn) state <= S_DROP;
                else begin cnt <= CW'(BIT_CLKS - 1); nb <= '0; state <= S_TBIT; end
        S_TBIT: if (cnt != '0) cnt <= cnt - 1'b1;
                else if (nb == 4'd8) begin
                  off <= off_inc[LEN_W-1:0]; turn <= (off_inc == {1'b0, cur_tx});
                  cnt <= CW'(BIT_CLKS - 1); state <= S_SYNL;
                end else begin
                  tsh <= {tsh[7:0], 1'b0}; nb <= nb + 1'b1; cnt <= CW'(BIT_CLKS - 1);
                end
        S_DROP: begin cnt <= CW'(HALF - 1); state <= S_TAW; end
        S_TAW: if (cnt != '0) cnt <= cnt - 1'b1;
               else begin
                 off <= '0; err <= 1'b0; state <= S_WLOW;
                 if (cur_rx == '0) begin set_en <= 1'b1; set_code <= 2'd1; ctx <= C_END; end
                 else ctx <= C_RXB;
               end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NIDX; g++) begin : g_st
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= 2'd0;
      else if (set_en && idx == 4'(g)) st <= set_code;
      else if (clr_i[g]) st <= 2'd0;
    end
    assign status_o[2*g +: 2] = st;
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !(set_en && idx == 4'(g))) |=> (st == 2'd0)) else $error("clear failed"); // R10
  end

  AST_ACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe_o) |-> line_o) else $error("first drive not high"); // R3
  AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe_o) |-> !$past(line_o)) else $error("released from high"); // R5
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o) else $error("write strobe too long"); // R6
  AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ({1'b0, wr_off_o} < {1'b0, rx_len_i[int'(wr_idx_o)*LEN_W +: LEN_W]}))
    else $error("write offset out of range"); // R6
  AST_SET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !line_oe_o) else $error("status set while driving"); // R7
endmodule

// File: tb/swire_target_bench.sv
module swire_target_bench;
  localparam int BIT = 16, HALF = 8, ACK = 8, LW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic i_oe = 1'b0, i_drv = 1'b1;
  logic line_oe_o, line_o, ln;
  logic [16*LW-1:0] txl_v, rxl_v;
  logic [3:0] rd_idx, wr_idx;
  logic [LW-1:0] rd_off, wr_off;
  logic [7:0] rd_data, wr_data;
  logic wr_en;
  logic [15:0] clr = '0;
  logic [31:0] st;

  assign ln = line_oe_o ? line_o : (i_oe ? i_drv : 1'b1);

  function automatic int txl(int i); return i % 5; endfunction
  function automatic int rxl(int i); return (i + 2) % 5; endfunction
  function automatic logic [7:0] fb(int i, int o); return 8'(i * 29 + o * 53 + 7); endfunction
  function automatic logic [7:0] gb(int i, int o); return 8'(i * 71 + o * 13 + 200); endfunction

  assign rd_data = fb(int'(rd_idx), int'(rd_off));

  swire_target #(.BIT_CLKS(BIT), .ACK_UNIT(2), .ACK_WIDTH(4), .LEN_W(LW)) u_swire_target (
    .clk(clk), .rst_n(rst_n), .line_i(ln), .line_oe_o(line_oe_o), .line_o(line_o),
    .tx_len_i(txl_v), .rx_len_i(rxl_v), .rd_idx_o(rd_idx), .rd_off_o(rd_off), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_off_o(wr_off), .wr_data_o(wr_data),
    .clr_i(clr), .status_o(st));

  int checks = 0, fails = 0, cyc = 0, wn = 0, contend = 0, tdrv = 0;
  bit done = 1'b0;
  int w_idx [16], w_off [16], w_dat [16];
  int exp_st [16];

  always @(negedge clk) begin
    if (line_oe_o && i_oe) contend++;
    if (line_oe_o) tdrv++;
    if (wr_en) begin
      if (wn < 16) begin w_idx[wn] = int'(wr_idx); w_off[wn] = int'(wr_off); w_dat[wn] = int'(wr_data); end
      wn++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic v, int n);
    i_oe = 1'b1; i_drv = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_chunk(logic [7:0] d, int nbits, bit flip);
    logic p = 1'b0;
    drive(1'b0, BIT);
    drive(1'b1, HALF);
    for (int k = nbits - 1; k >= 0; k--) begin
      drive(d[k], BIT);
      p ^= d[k];
    end
    drive(p ^ flip, BIT);
    i_drv = 1'b0;
  endtask

  task automatic start_idx(int i, bit flip);
    drive(1'b0, BIT);
    send_chunk(8'(i), 4, flip);
    drive(1'b0, 1);
    i_oe = 1'b0;
  endtask

  task automatic recv_chunk(output logic [7:0] d, output logic p);
    while (ln !== 1'b0) @(negedge clk);
    while (ln !== 1'b1) @(negedge clk);
    d = '0;
    for (int k = 0; k < 8; k++) begin
      repeat (BIT) @(negedge clk);
      d = {d[6:0], ln};
    end
    repeat (BIT) @(negedge clk);
    p = ln;
  endtask

  task automatic run_txn(int i, int bad);
    int n, es;
    logic [7:0] d;
    logic p;
    wn = 0; contend = 0;
    start_idx(i, 1'b0);
    while (!line_oe_o) @(negedge clk);
    n = 0;
    while (line_oe_o && line_o) begin n++; @(negedge clk); end
    chk(n == ACK, "R3 ack high width", n, ACK);
    chk(line_oe_o && !line_o, "R3 ack falls to driven low", int'(ln), 0);
    for (int o = 0; o < txl(i); o++) begin
      recv_chunk(d, p);
      chk(d == fb(i, o), "R4 sent byte value", int'(d), int'(fb(i, o)));
      chk(p == ^d, "R4 sent parity bit", int'(p), int'(^d));
    end
    while (ln !== 1'b0) @(negedge clk);
    while (ln !== 1'b1) @(negedge clk);
    n = 0;
    while (line_oe_o && line_o) begin n++; @(negedge clk); end
    chk(n == HALF, "R5 turnaround high width", n, HALF);
    chk(line_oe_o && !line_o, "R5 one clock low before release", int'(line_oe_o), 1);
    @(negedge clk);
    chk(!line_oe_o, "R5 line released", int'(line_oe_o), 0);
    repeat (BIT - HALF - 1) @(negedge clk);
    i_oe = 1'b1; i_drv = 1'b0;
    for (int o = 0; o < rxl(i); o++) send_chunk(gb(i, o), 8, o == bad);
    drive(1'b0, BIT);
    drive(1'b1, 4);
    i_oe = 1'b0;
    repeat (4) @(negedge clk);
    chk(wn == rxl(i), "R6 write strobe count", wn, rxl(i));
    for (int o = 0; o < rxl(i) && o < wn; o++) begin
      chk(w_idx[o] == i && w_off[o] == o, "R6 write address", w_idx[o] * 16 + w_off[o], i * 16 + o);
      chk(w_dat[o] == int'(gb(i, o)), "R6 write data", w_dat[o], int'(gb(i, o)));
    end
    es = (rxl(i) == 0) ? 1 : ((bad >= 0 && bad < rxl(i)) ? 2 : 1);
    exp_st[i] = es;
    if (rxl(i) == 0) chk(int'(st[2*i +: 2]) == es, "R8 empty receive accepted", int'(st[2*i +: 2]), es);
    else chk(int'(st[2*i +: 2]) == es, "R7 status code", int'(st[2*i +: 2]), es);
    chk(contend == 0, "R5 no drive overlap", contend, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      txl_v[i*LW +: LW] = LW'(txl(i));
      rxl_v[i*LW +: LW] = LW'(rxl(i));
      exp_st[i] = 0;
    end
    repeat (5) @(negedge clk);
    chk(st == '0, "R1 status after reset", int'(st), 0);
    chk(!line_oe_o, "R1 line released after reset", int'(line_oe_o), 0);
    chk(!wr_en, "R1 no write after reset", int'(wr_en), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    foreach (exp_st[j]) if (j % 5 == 0 && j > 0) begin
      tdrv = 0;
      start_idx(j, 1'b1);
      repeat (3 * BIT) @(negedge clk);
      chk(tdrv == 0, "R2 bad index parity never drives", tdrv, 0);
      chk(st == '0, "R2 bad index leaves status", int'(st), 0);
    end

    run_txn(10, -1);
    chk(int'(st[21:20]) == exp_st[10], "R9 accepted after dropped index", int'(st[21:20]), exp_st[10]);

    for (int i = 0; i < 16; i++) run_txn(i, (i % 3 == 1) ? rxl(i) - 1 : -1);

    run_txn(4, -1);
    chk(int'(st[9:8]) == 1, "R7 error does not carry over", int'(st[9:8]), 1);

    clr[7] = 1'b1;
    @(negedge clk);
    clr = '0;
    @(negedge clk);
    exp_st[7] = 0;
    chk(st[15:14] == 2'd0, "R10 cleared index", int'(st[15:14]), 0);
    for (int i = 0; i < 16; i++)
      chk(int'(st[2*i +: 2]) == exp_st[i], "R10 other index untouched", int'(st[2*i +: 2]), exp_st[i]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule